// File: doc/BRIEF.md
# Persistence-Aware Victim Selector for a Nonvolatile Last-Level Cache

This block holds the persistence bookkeeping for every line of a nonvolatile last-level cache and chooses which way to replace on a miss. Each line carries a two-bit persistence state and the identity of the transaction that owns it. A persistent-space write, whether it hits or fills, leaves the line pending for its transaction. A commit on that line turns it persistent. Lines in volatile address space stay free.

Victims are chosen by least-recently-used order, but pending lines are masked out of the search. A miss whose set is entirely pending cannot be served. If the upper-level request queue is also close to full, the block stalls the requester and raises a fall-back interrupt for one cycle. After a restart, a recovery scan walks the sets one per cycle and discards every pending line, so only committed data survives. The data array and the fall-back mechanism are outside the block.

Top module: `nvc_victim_sel`

## Requirements
- R1: After reset every line is free (state 00), clean and owned by ID 0. No victim, stall or interrupt is reported. The LRU order in each set starts with way 0 as oldest, then way 1, and so on up to the last way.
- R2: The line state codes are free = 00, pending = 01 and persistent = 10. The owner ID is the concatenation of core, thread and transaction indices and is log2(cores)+log2(threads)+log2(transactions) bits wide (12 bits by default). The probe port reports both for the line it addresses.
- R3: A persistent write (write and persistent flag set), on a hit or a fill, makes the line pending with the request's owner ID. A non-persistent write makes the line free with owner 0. Any write marks the line dirty. A read fill leaves the line free, clean and owned by 0.
- R4: A commit turns a pending line persistent and keeps its owner. A commit to a line that is not pending changes nothing.
- R5: On a miss, the victim is the least recently used way among the ways that are not pending. A pending way is never chosen.
- R6: Every hit and every fill makes the touched way most recently used. Pending lines keep their place in the order while they are excluded.
- R7: One cycle after a serviced miss, victim_valid_o pulses with the victim way. victim_wb_o is 1 exactly when the replaced line was dirty.
- R8: A miss in a set where every way is pending is not filled and reports no victim. If queue_level_i*5 >= QDEPTH*4 in that cycle, stall_o and irq_o pulse one cycle later. Otherwise neither pulses.
- R9: A pulse on recover_i starts a scan of SETS cycles, one set per cycle, during which stall_o stays high. Each pending line becomes free, clean and owned by 0. Persistent lines keep their state. Accesses and commits presented during the scan are ignored.
- R10: A read hit changes no line state, owner or dirty bit. It only updates the LRU order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | Access request present |
| acc_set_i | input | $clog2(SETS) | Set index of the access |
| acc_hit_i | input | 1 | 1 = hit, 0 = miss |
| acc_way_i | input | $clog2(WAYS) | Hit way (used on hits only) |
| acc_write_i | input | 1 | Access is a write |
| acc_persist_i | input | 1 | Address lies in persistent space |
| acc_owner_i | input | OW | Owner ID {core, thread, transaction} |
| cmt_valid_i | input | 1 | Commit request for one line |
| cmt_set_i | input | $clog2(SETS) | Set of the committing line |
| cmt_way_i | input | $clog2(WAYS) | Way of the committing line |
| queue_level_i | input | $clog2(QDEPTH+1) | Upper-level request queue occupancy |
| recover_i | input | 1 | Start the post-restart recovery scan |
| peek_set_i | input | $clog2(SETS) | Probe set |
| peek_way_i | input | $clog2(WAYS) | Probe way |
| victim_valid_o | output | 1 | Victim chosen for the previous miss |
| victim_way_o | output | $clog2(WAYS) | Victim way |
| victim_wb_o | output | 1 | Victim was dirty and needs write-back |
| stall_o | output | 1 | Stall requests (fall-back or scan) |
| irq_o | output | 1 | Fall-back interrupt pulse |
| peek_state_o | output | 2 | State of the probed line |
| peek_owner_o | output | OW | Owner ID of the probed line |

## Verification
Victim, write-back flag, stall and interrupt are all registered. Each is due exactly one rising edge after the access is sampled. State changes from an access, a commit or a scan step can be read on the probe port right after the edge that applies them. The recovery scan holds stall_o from the edge that samples recover_i until SETS edges later. The bench drives inputs at the falling edge and updates its reference model at the rising edge. It compares outputs and the probe shortly after the next falling edge, which is where each result is due.

// File: rtl/nvc_pkg.sv
package nvc_pkg;
  typedef enum logic [1:0] {
    LS_FREE = 2'b00,
    LS_PEND = 2'b01,
    LS_PERS = 2'b10
  } line_st_e;
endpackage

// File: rtl/nvc_line_tbl.sv
module nvc_line_tbl
  import nvc_pkg::*;
#(
  parameter int SETS = 8,
  parameter int WAYS = 16,
  parameter int OW   = 12,
  localparam int SW  = $clog2(SETS),
  localparam int WW  = $clog2(WAYS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            upd_en_i,
  input  logic [SW-1:0]   upd_set_i,
  input  logic [WW-1:0]   upd_way_i,
  input  line_st_e        upd_state_i,
  input  logic [OW-1:0]   upd_owner_i,
  input  logic            upd_dirty_i,
  input  logic            cmt_en_i,
  input  logic [SW-1:0]   cmt_set_i,
  input  logic [WW-1:0]   cmt_way_i,
  input  logic            scan_en_i,
  input  logic [SW-1:0]   scan_set_i,
  input  logic [SW-1:0]   rd_set_i,
  input  logic [SW-1:0]   peek_set_i,
  input  logic [WW-1:0]   peek_way_i,
  output logic [WAYS-1:0] pend_mask_o,
  output logic [WAYS-1:0] dirty_row_o,
  output line_st_e        peek_state_o,
  output logic [OW-1:0]   peek_owner_o
);
  line_st_e    st_q    [SETS][WAYS];
  logic [OW-1:0] own_q [SETS][WAYS];
  logic        dirty_q [SETS][WAYS];

  // priority per line: recovery scan, then access update, then commit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          st_q[s][w]    <= LS_FREE;
          own_q[s][w]   <= '0;
          dirty_q[s][w] <= 1'b0;
        end
      end
    end else begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          if (scan_en_i && scan_set_i == SW'(s)) begin
            if (st_q[s][w] == LS_PEND) begin
              st_q[s][w]    <= LS_FREE;
              own_q[s][w]   <= '0;
              dirty_q[s][w] <= 1'b0;
            end
          end else if (upd_en_i && upd_set_i == SW'(s) && upd_way_i == WW'(w)) begin
            st_q[s][w]    <= upd_state_i;
            own_q[s][w]   <= upd_owner_i;
            dirty_q[s][w] <= upd_dirty_i;
          end else if (cmt_en_i && cmt_set_i == SW'(s) && cmt_way_i == WW'(w)
                       && st_q[s][w] == LS_PEND) begin
            st_q[s][w] <= LS_PERS;
          end
        end
      end
    end
  end

  for (genvar gw = 0; gw < WAYS; gw++) begin : g_row
    assign pend_mask_o[gw] = (st_q[rd_set_i][gw] == LS_PEND);
    assign dirty_row_o[gw] = dirty_q[rd_set_i][gw];
  end

  assign peek_state_o = st_q[peek_set_i][peek_way_i];
  assign peek_owner_o = own_q[peek_set_i][peek_way_i];
endmodule

// File: rtl/nvc_lru.sv
module nvc_lru #(
  parameter int SETS = 8,
  parameter int WAYS = 16,
  localparam int SW  = $clog2(SETS),
  localparam int WW  = $clog2(WAYS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            touch_en_i,
  input  logic [SW-1:0]   touch_set_i,
  input  logic [WW-1:0]   touch_way_i,
  input  logic [SW-1:0]   rd_set_i,
  input  logic [WAYS-1:0] excl_i,
  output logic [WW-1:0]   vict_way_o,
  output logic            vict_ok_o
);
  // age 0 = most recent; ages in a set are a permutation
  logic [WW-1:0] age_q [SETS][WAYS];
  logic [WW-1:0] row_age [WAYS];
  logic [WW-1:0] t_age;

  assign t_age = age_q[touch_set_i][touch_way_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= WW'(WAYS - 1 - w);
    end else if (touch_en_i) begin
      for (int s = 0; s < SETS; s++) begin
        if (touch_set_i == SW'(s)) begin
          for (int w = 0; w < WAYS; w++) begin
            if (touch_way_i == WW'(w))     age_q[s][w] <= '0;
            else if (age_q[s][w] < t_age)  age_q[s][w] <= age_q[s][w] + 1'b1;
          end
        end
      end
    end
  end

  for (genvar gw = 0; gw < WAYS; gw++) begin : g_age
    assign row_age[gw] = age_q[rd_set_i][gw];
  end

  always_comb begin
    logic [WW-1:0] best;
    best       = '0;
    vict_way_o = '0;
    vict_ok_o  = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (!excl_i[w] && (!vict_ok_o || row_age[w] > best)) begin
        vict_ok_o  = 1'b1;
        vict_way_o = WW'(w);
        best       = row_age[w];
      end
    end
  end
endmodule

// File: rtl/nvc_ovf_det.sv
module nvc_ovf_det #(
  parameter int QDEPTH = 16,
  localparam int QW    = $clog2(QDEPTH + 1),
  localparam int unsigned FULL_X5 = QDEPTH * 4
) (
  input  logic          blocked_miss_i,
  input  logic [QW-1:0] level_i,
  output logic          fallback_o
);
  logic near_full;
  // level/depth >= 0.8 without a divider
  assign near_full  = (32'(level_i) * 32'd5) >= 32'(FULL_X5);
  assign fallback_o = blocked_miss_i & near_full;
endmodule

// File: rtl/nvc_victim_sel.sv
module nvc_victim_sel
  import nvc_pkg::*;
#(
  parameter int SETS    = 8,
  parameter int WAYS    = 16,
  parameter int CORES   = 8,
  parameter int THREADS = 2,
  parameter int TXNS    = 256,
  parameter int QDEPTH  = 16,
  localparam int SW = $clog2(SETS),
  localparam int WW = $clog2(WAYS),
  localparam int OW = $clog2(CORES) + $clog2(THREADS) + $clog2(TXNS),
  localparam int QW = $clog2(QDEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acc_valid_i,
  input  logic [SW-1:0] acc_set_i,
  input  logic          acc_hit_i,
  input  logic [WW-1:0] acc_way_i,
  input  logic          acc_write_i,
  input  logic          acc_persist_i,
  input  logic [OW-1:0] acc_owner_i,
  input  logic          cmt_valid_i,
  input  logic [SW-1:0] cmt_set_i,
  input  logic [WW-1:0] cmt_way_i,
  input  logic [QW-1:0] queue_level_i,
  input  logic          recover_i,
  input  logic [SW-1:0] peek_set_i,
  input  logic [WW-1:0] peek_way_i,
  output logic          victim_valid_o,
  output logic [WW-1:0] victim_way_o,
  output logic          victim_wb_o,
  output logic          stall_o,
  output logic          irq_o,
  output logic [1:0]    peek_state_o,
  output logic [OW-1:0] peek_owner_o
);
  logic            busy_q;
  logic [SW-1:0]   scan_cnt_q;
  logic            acc_go, fill, ovf_miss, pwr, fallback;
  logic [WAYS-1:0] pend_mask, dirty_row;
  logic [WW-1:0]   vict_way, tgt_way;
  logic            vict_ok;
  logic            upd_en, touch_en;
  line_st_e        upd_state, peek_st;
  logic            stall_q, irq_q;

  assign acc_go    = acc_valid_i & ~busy_q;
  assign fill      = acc_go & ~acc_hit_i & vict_ok;
  assign ovf_miss  = acc_go & ~acc_hit_i & ~vict_ok;
  assign tgt_way   = acc_hit_i ? acc_way_i : vict_way;
  assign pwr       = acc_write_i & acc_persist_i;
  assign upd_en    = fill | (acc_go & acc_hit_i & acc_write_i);
  assign upd_state = pwr ? LS_PEND : LS_FREE;
  assign touch_en  = acc_go & (acc_hit_i | fill);

  nvc_line_tbl #(.SETS(SETS), .WAYS(WAYS), .OW(OW)) u_tbl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .upd_en_i     (upd_en),
    .upd_set_i    (acc_set_i),
    .upd_way_i    (tgt_way),
    .upd_state_i  (upd_state),
    .upd_owner_i  (pwr ? acc_owner_i : '0),
    .upd_dirty_i  (acc_write_i),
    .cmt_en_i     (cmt_valid_i & ~busy_q),
    .cmt_set_i    (cmt_set_i),
    .cmt_way_i    (cmt_way_i),
    .scan_en_i    (busy_q),
    .scan_set_i   (scan_cnt_q),
    .rd_set_i     (acc_set_i),
    .peek_set_i   (peek_set_i),
    .peek_way_i   (peek_way_i),
    .pend_mask_o  (pend_mask),
    .dirty_row_o  (dirty_row),
    .peek_state_o (peek_st),
    .peek_owner_o (peek_owner_o)
  );

  nvc_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .touch_en_i  (touch_en),
    .touch_set_i (acc_set_i),
    .touch_way_i (tgt_way),
    .rd_set_i    (acc_set_i),
    .excl_i      (pend_mask),
    .vict_way_o  (vict_way),
    .vict_ok_o   (vict_ok)
  );

  nvc_ovf_det #(.QDEPTH(QDEPTH)) u_ovf (
    .blocked_miss_i (ovf_miss),
    .level_i        (queue_level_i),
    .fallback_o     (fallback)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      scan_cnt_q <= '0;
    end else if (busy_q) begin
      if (scan_cnt_q == SW'(SETS - 1)) busy_q <= 1'b0;
      else                             scan_cnt_q <= scan_cnt_q + 1'b1;
    end else if (recover_i) begin
      busy_q     <= 1'b1;
      scan_cnt_q <= '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      victim_valid_o <= 1'b0;
      victim_way_o   <= '0;
      victim_wb_o    <= 1'b0;
      stall_q        <= 1'b0;
      irq_q          <= 1'b0;
    end else begin
      victim_valid_o <= fill;
      if (fill) victim_way_o <= vict_way;
      victim_wb_o    <= fill & dirty_row[vict_way];
      stall_q        <= fallback;
      irq_q          <= fallback;
    end
  end

  assign stall_o      = stall_q | busy_q;
  assign irq_o        = irq_q;
  assign peek_state_o = peek_st;
endmodule

// File: rtl/nvc_victim_sel_chk.sv
module nvc_victim_sel_chk #(
  parameter int WAYS = 16,
  parameter int WW   = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            fill,
  input logic            ovf_miss,
  input logic [WAYS-1:0] pend_mask,
  input logic [WW-1:0]   vict_way,
  input logic            busy_q,
  input logic            victim_valid_o,
  input logic            stall_o
);
  // R5: victim from the LRU unit is never a pending way in the line table
  a_r5_victim_not_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill |-> !pend_mask[vict_way]);

  // R8: a blocked miss only happens when the whole set is pending
  a_r8_ovf_all_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_miss |-> (&pend_mask));

  // R8: no victim follows a blocked miss
  a_r8_no_victim_after_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_miss |=> !victim_valid_o);

  // R9: stall held throughout the scan
  a_r9_stall_in_scan: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> stall_o);

  // R9: accesses during the scan produce no victim
  a_r9_no_victim_in_scan: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> !victim_valid_o);
endmodule

bind nvc_victim_sel nvc_victim_sel_chk #(.WAYS(WAYS), .WW(WW)) u_chk (.*);

// File: tb/nvc_victim_sel_test.sv
module nvc_victim_sel_test;
  localparam int CLK_P  = 10;
  localparam int SETS   = 8;
  localparam int WAYS   = 16;
  localparam int OW     = 12;
  localparam int QDEPTH = 16;
  localparam int QW     = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic acc_valid = 0, acc_hit = 0, acc_write = 0, acc_persist = 0;
  logic [2:0] acc_set = '0, cmt_set = '0, peek_set = '0;
  logic [3:0] acc_way = '0, cmt_way = '0, peek_way = '0;
  logic [OW-1:0] acc_owner = '0;
  logic cmt_valid = 0, recover = 0;
  logic [QW-1:0] qlevel = '0;
  logic vv, wb, stall, irq;
  logic [3:0] vway;
  logic [1:0] pst;
  logic [OW-1:0] pown;

  int errors = 0, checks = 0;
  string tag = "R1";

  nvc_victim_sel uut (
    .clk_i(clk), .rst_ni(rst_n),
    .acc_valid_i(acc_valid), .acc_set_i(acc_set), .acc_hit_i(acc_hit),
    .acc_way_i(acc_way), .acc_write_i(acc_write), .acc_persist_i(acc_persist),
    .acc_owner_i(acc_owner), .cmt_valid_i(cmt_valid), .cmt_set_i(cmt_set),
    .cmt_way_i(cmt_way), .queue_level_i(qlevel), .recover_i(recover),
    .peek_set_i(peek_set), .peek_way_i(peek_way),
    .victim_valid_o(vv), .victim_way_o(vway), .victim_wb_o(wb),
    .stall_o(stall), .irq_o(irq), .peek_state_o(pst), .peek_owner_o(pown)
  );

  always #(CLK_P/2) clk = ~clk;

  // reference model: states 0 free, 1 pending, 2 persistent; recency by timestamp
  int m_st [SETS][WAYS];
  int m_own [SETS][WAYS];
  bit m_dirty [SETS][WAYS];
  int m_stamp [SETS][WAYS];
  int m_time;
  bit m_busy;
  int m_cnt;
  bit e_vv, e_wb, e_fb;
  int e_way;

  task automatic m_reset();
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        m_st[s][w] = 0; m_own[s][w] = 0; m_dirty[s][w] = 0; m_stamp[s][w] = w;
      end
    m_time = WAYS; m_busy = 0; m_cnt = 0; e_vv = 0; e_wb = 0; e_fb = 0; e_way = 0;
  endtask

  task automatic m_write(int s, int w);
    bit p;
    p = acc_write && acc_persist;
    m_st[s][w]    = p ? 1 : 0;
    m_own[s][w]   = p ? int'(acc_owner) : 0;
    m_dirty[s][w] = acc_write;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_reset();
    else begin
      e_vv = 0; e_wb = 0; e_fb = 0;
      if (m_busy) begin
        for (int w = 0; w < WAYS; w++)
          if (m_st[m_cnt][w] == 1) begin
            m_st[m_cnt][w] = 0; m_own[m_cnt][w] = 0; m_dirty[m_cnt][w] = 0;
          end
        if (m_cnt == SETS - 1) m_busy = 0; else m_cnt++;
      end else begin
        if (cmt_valid && m_st[cmt_set][cmt_way] == 1) m_st[cmt_set][cmt_way] = 2;
        if (acc_valid) begin
          int s;
          s = acc_set;
          if (acc_hit) begin
            if (acc_write) m_write(s, acc_way);
            m_stamp[s][acc_way] = m_time++;
          end else begin
            int v;
            v = -1;
            for (int w = 0; w < WAYS; w++)
              if (m_st[s][w] != 1 && (v < 0 || m_stamp[s][w] < m_stamp[s][v])) v = w;
            if (v >= 0) begin
              e_vv = 1; e_way = v; e_wb = m_dirty[s][v];
              m_write(s, v);
              m_stamp[s][v] = m_time++;
            end else if (int'(qlevel) * 5 >= QDEPTH * 4) e_fb = 1;
          end
        end
        if (recover) begin m_busy = 1; m_cnt = 0; end
      end
    end
  end

  task automatic chk(string t, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", t, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the rising edge
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      chk({tag, " victim_valid"}, vv, e_vv);
      if (e_vv) begin
        chk({tag, " victim_way"}, vway, e_way);
        chk({tag, " victim_wb"}, wb, e_wb);
      end
      chk({tag, " stall"}, stall, e_fb | m_busy);
      chk({tag, " irq"}, irq, e_fb);
      chk({tag, " peek_state"}, pst, m_st[peek_set][peek_way]);
      chk({tag, " peek_owner"}, pown, m_own[peek_set][peek_way]);
    end
  end

  int l_vv, l_way, l_wb, l_stall, l_irq;

  task automatic access(int s, int w, bit hit, bit wr, bit pers, int own, int lvl);
    @(negedge clk);
    acc_valid = 1; acc_set = 3'(s); acc_way = 4'(w); acc_hit = hit;
    acc_write = wr; acc_persist = pers; acc_owner = OW'(own); qlevel = QW'(lvl);
    @(negedge clk);
    acc_valid = 0;
    #2;
    l_vv = vv; l_way = vway; l_wb = wb; l_stall = stall; l_irq = irq;
  endtask

  task automatic commit(int s, int w);
    @(negedge clk);
    cmt_valid = 1; cmt_set = 3'(s); cmt_way = 4'(w);
    @(negedge clk);
    cmt_valid = 0;
  endtask

  task automatic peek(int s, int w);
    @(negedge clk);
    peek_set = 3'(s); peek_way = 4'(w);
    #2;
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    tag = "R1";
    peek(1, 0);
    chk("R1 reset state", pst, 0);
    chk("R1 reset stall", stall, 0);
    access(1, 0, 0, 0, 0, 0, 0);
    chk("R1 first victim way", l_way, 0);
    chk("R7 read-fill no wb", l_wb, 0);
    // R2: owner width and encodings
    tag = "R2";
    chk("R2 owner width", $bits(pown), 12);
    // R3: persistent write fill -> pending, non-persistent write -> free
    tag = "R3";
    access(2, 0, 0, 1, 1, 12'h5A3, 0);
    peek(2, 0);
    chk("R3 pending after persistent fill", pst, 1);
    chk("R3 owner", pown, 12'h5A3);
    access(2, 0, 1, 1, 0, 12'h777, 0);
    peek(2, 0);
    chk("R3 free after plain write", pst, 0);
    access(2, 0, 1, 1, 1, 12'h0F0, 0);
    // R6/R5: fill set 3, make the LRU way pending, then reorder with hits
    tag = "R6";
    for (int i = 0; i < WAYS; i++) access(3, 0, 0, 1, 0, 0, 0);
    access(3, 0, 1, 1, 1, 12'h111, 0);
    for (int i = 1; i < WAYS; i++) access(3, i, 1, 0, 0, 0, 0);
    tag = "R5";
    access(3, 0, 0, 1, 0, 0, 0);
    chk("R5 pending LRU skipped", l_way, 1);
    chk("R7 dirty victim wb", l_wb, 1);
    // R4: commit frees the way for eviction
    tag = "R4";
    commit(3, 0);
    peek(3, 0);
    chk("R4 persistent after commit", pst, 2);
    chk("R4 owner kept", pown, 12'h111);
    access(3, 0, 0, 0, 0, 0, 0);
    chk("R6 committed way is LRU", l_way, 0);
    commit(1, 5);
    peek(1, 5);
    chk("R4 commit on free ignored", pst, 0);
    // R8: overflow
    tag = "R8";
    for (int i = 0; i < WAYS; i++) access(4, 0, 0, 1, 1, 12'h300 + i, 0);
    access(4, 0, 0, 0, 0, 0, 12);
    chk("R8 no victim on overflow", l_vv, 0);
    chk("R8 no stall below threshold", l_stall, 0);
    access(4, 0, 0, 0, 0, 0, 13);
    chk("R8 stall at threshold", l_stall, 1);
    chk("R8 irq at threshold", l_irq, 1);
    // R10: read hit leaves state alone
    tag = "R10";
    access(2, 0, 1, 0, 0, 0, 0);
    peek(2, 0);
    chk("R10 state kept", pst, 1);
    chk("R10 owner kept", pown, 12'h0F0);
    // R9: recovery scan
    tag = "R9";
    access(5, 0, 0, 1, 1, 12'h222, 0);
    commit(5, 0);
    access(5, 0, 0, 1, 1, 12'h223, 0);
    @(negedge clk); recover = 1;
    @(negedge clk); recover = 0;
    commit(2, 0);
    access(6, 0, 0, 1, 1, 12'h444, 0);
    chk("R9 access ignored in scan", l_vv, 0);
    chk("R9 stall in scan", l_stall, 1);
    repeat (10) @(negedge clk);
    peek(5, 0);
    chk("R9 persistent kept", pst, 2);
    peek(5, 1);
    chk("R9 pending dropped", pst, 0);
    peek(2, 0);
    chk("R9 commit ignored in scan", pst, 0);
    peek(6, 0);
    chk("R9 no fill in scan", pst, 0);
    access(4, 0, 0, 0, 0, 0, 0);
    chk("R9 set usable after scan", l_vv, 1);
    chk("R9 dropped line clean", l_wb, 0);
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule